// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block is a transmit-only serial master that keeps refreshing a two-channel 8-bit serial DAC. It sends one 16-bit word after another. Each word carries a control byte in its upper half and a data byte in its lower half, most significant bit first. The serial clock comes from the system clock through an internal divider. The link runs in mode 0: the clock idles low, the DAC samples on rising edges, and the block changes the data line only on falling edges. A new bit is therefore steady for half a serial period before the DAC takes it.

A four-step sequencer controls every word. The steps, in order, are idle, load, start and shift, and the sequencer takes at most one step per serial-clock falling edge. The idle step raises chip-select. The load step captures the two byte inputs and clears the done flag. The start step lowers chip-select and presents the first bit. The shift step presents the remaining fifteen bits. On the last bit it raises done and returns to idle, so words repeat without any trigger from outside. The application sets the control and data bytes on input ports. A typical setting is control 0x00 with data 0x7F, which drives both DAC channels to the same mid-scale value.

Top module: `spi_dac_frame_tx`

## Requirements
- R1: While `rst_n` is low, `cs_n` is 1, `sclk` is 0, `mosi` is 0 and `done` is 0.
- R2: `sclk` stays 0 whenever `cs_n` is 1. While `cs_n` is 0 it has a period of CLK_DIV system cycles (default 6) and is high for the second half of each period.
- R3: `mosi` changes only on a system edge where the serial clock falls. It is therefore constant across every rising edge of `sclk`.
- R4: Each word has exactly 16 rising edges of `sclk` while `cs_n` is 0. The bits sampled on those edges are `{ctrl_byte, data_byte}`, bit 15 first. With inputs 0x00 and 0x7F the captured word is 0x007F.
- R5: The byte inputs are taken only in the load step. A change made while a word is being sent has no effect on that word and first appears in the next word.
- R6: `cs_n` falls on the falling edge of the start step and rises on the falling edge of the idle step that follows the last bit. Between words it stays high for two serial periods, so one word takes 18 serial periods.
- R7: `done` rises on the falling edge that presents bit 0, while `cs_n` is still 0. It stays high until the falling edge of the next load step and is 0 at every other time.
- R8: Words follow one another continuously after reset with no external request.
- R9: After reset is released, `cs_n` first falls on the third serial falling edge, which is 3*CLK_DIV system cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctrl_byte | input | CTRL_W (8) | Control byte, sent first |
| data_byte | input | DATA_W (8) | Data byte, sent second |
| sclk | output | 1 | Serial clock, mode 0, held low outside a word |
| cs_n | output | 1 | Active-low chip-select |
| mosi | output | 1 | Serial data, MSB first |
| done | output | 1 | High from the last bit of a word until the next load step |

## Verification
The hardest case to reach from the ports is R5: the inputs change while a word is already being sent. The window is tight, because the load step takes the bytes one serial period before chip-select falls. The stimulus therefore waits for the falling edge of `cs_n`, then swaps both bytes on the next system edge. It checks that the word in flight keeps the old value and that the following word carries the new one. A reset asserted in the middle of a word covers R1 and R9 a second time from a state other than power-up.

// File: rtl/spi_dac_pkg.sv
package spi_dac_pkg;

  // Sequencer steps; the encoding order is also the order of the steps.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_START = 2'd2,
    ST_SHIFT = 2'd3
  } seq_state_e;

endpackage

// File: rtl/spi_dac_sclk_div.sv
// Free-running serial clock divider. CLK_DIV must be even and at least 2.
module spi_dac_sclk_div #(
  parameter int CLK_DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk_q,
  output logic fall_tick
);

  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_d;
  logic          half_done;

  assign half_done = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d  = half_done ? '0 : cnt_q + 1'b1;
    sclk_d = half_done ? ~sclk_q : sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  // High on the system edge at which the serial clock goes low.
  assign fall_tick = half_done & sclk_q;

endmodule

// File: rtl/spi_dac_shreg.sv
// Parallel-load, left-shifting word register.
module spi_dac_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         shift_en,
  input  logic [W-1:0] load_val,
  output logic         msb
);

  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (load_en)
      word_d = load_val;
    else if (shift_en)
      word_d = {word_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      word_q <= '0;
    else
      word_q <= word_d;
  end

  assign msb = word_q[W-1];

endmodule

// File: rtl/spi_dac_seq.sv
// Idle/load/start/shift sequencer; steps only when adv is high.
module spi_dac_seq
  import spi_dac_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic msb,
  output logic load_en,
  output logic shift_en,
  output logic cs_n,
  output logic mosi,
  output logic done
);

  localparam int BCW = $clog2(FRAME_W);
  localparam logic [BCW-1:0] CNT_TOP = BCW'(FRAME_W - 1);

  seq_state_e     state_q, state_d;
  logic [BCW-1:0] left_q, left_d;
  logic           cs_n_d, mosi_d, done_d;

  always_comb begin
    state_d  = state_q;
    left_d   = left_q;
    cs_n_d   = cs_n;
    mosi_d   = mosi;
    done_d   = done;
    load_en  = 1'b0;
    shift_en = 1'b0;
    if (adv) begin
      unique case (state_q)
        ST_IDLE: begin
          cs_n_d  = 1'b1;
          state_d = ST_LOAD;
        end
        ST_LOAD: begin
          done_d  = 1'b0;
          left_d  = CNT_TOP;
          load_en = 1'b1;
          state_d = ST_START;
        end
        ST_START: begin
          cs_n_d   = 1'b0;
          mosi_d   = msb;
          shift_en = 1'b1;
          left_d   = left_q - 1'b1;
          state_d  = ST_SHIFT;
        end
        ST_SHIFT: begin
          mosi_d   = msb;
          shift_en = 1'b1;
          if (left_q == '0) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            left_d = left_q - 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      cs_n    <= cs_n_d;
      mosi    <= mosi_d;
      done    <= done_d;
    end
  end

endmodule

// File: rtl/spi_dac_frame_tx.sv
module spi_dac_frame_tx #(
  parameter int CLK_DIV = 6,
  parameter int CTRL_W  = 8,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_byte,
  input  logic [DATA_W-1:0] data_byte,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic              done
);

  localparam int FRAME_W = CTRL_W + DATA_W;

  logic sclk_q;
  logic fall_tick;
  logic load_en;
  logic shift_en;
  logic word_msb;

  spi_dac_sclk_div #(
    .CLK_DIV (CLK_DIV)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_q    (sclk_q),
    .fall_tick (fall_tick)
  );

  spi_dac_seq #(
    .FRAME_W (FRAME_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (fall_tick),
    .msb      (word_msb),
    .load_en  (load_en),
    .shift_en (shift_en),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .done     (done)
  );

  spi_dac_shreg #(
    .W (FRAME_W)
  ) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .shift_en (shift_en),
    .load_val ({ctrl_byte, data_byte}),
    .msb      (word_msb)
  );

  // Serial clock reaches the pin only inside a word (mode 0 idle low).
  assign sclk = sclk_q & ~cs_n;

endmodule

// File: rtl/spi_dac_frame_tx_chk.sv
module spi_dac_frame_tx_chk #(
  parameter int FRAME_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cs_n,
  input logic mosi,
  input logic done,
  input logic fall_tick
);

  localparam int RCW = $clog2(FRAME_W + 2);

  logic [RCW-1:0] rise_cnt;
  logic           sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt  <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_prev <= sclk;
      if (cs_n)
        rise_cnt <= '0;
      else if (sclk && !sclk_prev)
        rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_sclk_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_mosi_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mosi != $past(mosi)) |-> $past(fall_tick));

  assert_word_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_cnt == RCW'(FRAME_W)));

  assert_cs_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(done) && $past(fall_tick)));

  assert_done_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!cs_n && $past(fall_tick)));

endmodule

bind spi_dac_frame_tx spi_dac_frame_tx_chk #(
  .FRAME_W (FRAME_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (sclk),
  .cs_n      (cs_n),
  .mosi      (mosi),
  .done      (done),
  .fall_tick (fall_tick)
);

// File: tb/spi_dac_frame_tx_tb.sv
module spi_dac_frame_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 6;
  localparam int STEPS      = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl_byte = 8'h00;
  logic [7:0] data_byte = 8'h7F;
  logic       sclk, cs_n, mosi, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dac_frame_tx #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .data_byte(data_byte),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .done(done)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: position in the schedule of serial falling edges.
  int         e = 0;
  int         nf, ph;
  bit         m_cs = 1, m_mosi = 0, m_done = 0, m_sclk = 0;
  logic [15:0] m_word = 16'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      e = 0; m_cs = 1; m_mosi = 0; m_done = 0;
    end else begin
      e++;
      if (e % DIV == 0) begin
        nf = e / DIV;
        ph = (nf - 1) % STEPS;
        if (ph == 0) m_cs = 1;
        else if (ph == 1) begin m_done = 0; m_word = {ctrl_byte, data_byte}; end
        else if (ph == 2) begin m_cs = 0; m_mosi = m_word[15]; end
        else begin
          m_mosi = m_word[17 - ph];
          if (ph == 17) m_done = 1;
        end
      end
    end
    m_sclk = rst_n && ((e % DIV) >= DIV/2) && !m_cs;
  end

  // Cycle compare and word capture, away from the active edge.
  bit          prev_sclk = 0, prev_cs = 1, first_pending = 0, want_default = 1;
  logic [15:0] cap = 16'h0, last_cap = 16'h0;
  int          ncap = 0;
  int          frames = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ncap = 0;
    end else begin
      check(cs_n === m_cs, "R6 cs_n", cs_n, m_cs);
      check(sclk === m_sclk, "R2 sclk", sclk, m_sclk);
      check(mosi === m_mosi, "R3 mosi", mosi, m_mosi);
      check(done === m_done, "R7 done", done, m_done);
      if (!cs_n && sclk && !prev_sclk) begin
        cap = {cap[14:0], mosi};
        ncap++;
      end
      if (!cs_n && prev_cs && first_pending) begin
        check(e == 3*DIV, "R9 first cs_n fall", e, 3*DIV);
        first_pending = 0;
      end
      if (cs_n && !prev_cs) begin
        check(ncap == 16, "R4 bit count", ncap, 16);
        check(cap == m_word, "R4 word", cap, m_word);
        if (want_default) check(cap == 16'h007F, "R4 default word", cap, 16'h007F);
        last_cap = cap;
        ncap = 0;
        frames++;
      end
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", frames, 10);
    finish_run();
  end

  int f0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cs_n && !sclk && !mosi && !done, "R1 reset outputs",
          {cs_n, sclk, mosi, done}, 4'b1000);
    @(posedge clk); #1 rst_n = 1; first_pending = 1;
    wait (frames >= 3);

    // R5: swap the inputs just after a word has started.
    @(negedge cs_n);
    f0 = frames;
    want_default = 0;
    @(posedge clk); #1 ctrl_byte = 8'hA5; data_byte = 8'h3C;
    wait (frames == f0 + 1);
    check(last_cap == 16'h007F, "R5 word in flight kept", last_cap, 16'h007F);
    wait (frames == f0 + 2);
    check(last_cap == 16'hA53C, "R5 new bytes next word", last_cap, 16'hA53C);

    @(posedge clk); #1 ctrl_byte = 8'hFF; data_byte = 8'h81;
    wait (frames == f0 + 4);
    check(last_cap == 16'hFF81, "R4 all-ones control", last_cap, 16'hFF81);

    // Reset in the middle of a word.
    @(negedge cs_n);
    repeat (20) @(posedge clk);
    #1 rst_n = 0;
    @(negedge clk);
    check(cs_n && !sclk && !mosi && !done, "R1 reset mid-word",
          {cs_n, sclk, mosi, done}, 4'b1000);
    ctrl_byte = 8'h00; data_byte = 8'h7F; want_default = 1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1; first_pending = 1;
    f0 = frames;
    wait (frames == f0 + 2);
    check(!first_pending, "R9 first fall seen after reset", first_pending, 0);
    check(frames >= 8, "R8 continuous words", frames, 8);
    finish_run();
  end

endmodule